// File: doc/BRIEF.md
# DMA Byte Counter and Burst Controller

This block paces byte transfers between an endpoint buffer and an external bus master. Software picks a burst size, loads a 16-bit byte count and sets the enable bit. The block then raises a request line. The master answers with an acknowledge for each byte it moves. A live down-counter tracks how many bytes are left. The request line drops at every burst boundary and again when the count runs out.

When a transfer ends, the block either stops and latches a sticky end-of-transfer interrupt, or, with auto-restart set, reloads the live counter from the programmed count and keeps going. Clearing the enable bit during a transfer aborts it and also raises the interrupt. A byte-wide command port reaches the configuration byte, the count and the interrupt clear. A bus-reset input stops the engine and drops auto-restart. It keeps the burst size and the programmed count.

Top module: `dma_burst_ctl`

## Requirements
- R1: After the asynchronous reset, the configuration readback is 0x00, the count readback is 0, the request line is low and the interrupt is low.
- R2: Command 0xF0 writes the configuration byte and command 0xF1 reads it. Bit 3 is enable, and its readback is the live running state. Bit 2 is auto-restart. Bits 1:0 are the burst selector. Bits 7:4 read as 0.
- R3: Burst selector 00, 01, 10 and 11 allow 1, 4, 8 and 16 bytes per request. After a full burst the request line is low for at least one cycle. The final burst is cut short when the count runs out.
- R4: A byte is transferred in each cycle in which request and acknowledge are both high, and it lowers the live count by one. An acknowledge while the request is low changes nothing.
- R5: Command 0xF2 takes two byte writes: first the low byte, then the high byte. The programmed count changes only on the high-byte write. Command 0xF3 takes two byte reads, low byte then high byte, and returns the live remaining count. Any other command in between restarts the byte order.
- R6: Writing 1 to the enable bit loads the live counter from the programmed count. This also applies when a transfer is already running.
- R7: When the live count reaches zero and auto-restart is clear, the enable bit clears and the interrupt sets one cycle after the last byte.
- R8: When the live count reaches zero, auto-restart is set and the programmed count is nonzero, the live counter reloads and requests resume without raising the interrupt.
- R9: With a programmed count of zero, enabling issues no request. The enable bit clears and the interrupt sets, whatever the auto-restart setting.
- R10: Writing 0 to the enable bit during a transfer drops the request on the next cycle, clears the enable bit and sets the interrupt.
- R11: The interrupt stays set until a write of command 0xF5 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R12: Bus reset clears the enable and auto-restart bits and does not raise the interrupt. It keeps the burst selector and the programmed count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rst | input | 1 | Synchronous bus-reset pulse |
| reg_stb | input | 1 | Register access strobe, one byte per cycle |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_cmd | input | 8 | Command code |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, valid in the strobe cycle |
| dma_req | output | 1 | Transfer request to the bus master |
| dma_ack | input | 1 | Per-byte acknowledge from the bus master |
| xfer_done_irq | output | 1 | Sticky end-of-transfer interrupt |

## Verification
The bench goes after the burst boundaries. A design that miscounts the burst size, or skips the idle cycle between bursts, shows the wrong number of request pulses for a given count. It also checks that the last short burst stops at zero rather than running to a full burst. The bench commits a count only through its high byte. A design that commits on the low byte would return a wrong count after a lone low-byte write. The bench also covers abort, zero count with auto-restart, and bus reset. A design that misses the interrupt on abort, spins forever on a zero count, or wipes the burst size or programmed count on bus reset fails at the interrupt line or in a readback.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 2 * DATA_W;
  localparam int MAX_BURST = 16;
  localparam int BCNT_W    = $clog2(MAX_BURST);

  typedef enum logic [DATA_W-1:0] {
    CMD_CFG_WR  = 8'hF0,
    CMD_CFG_RD  = 8'hF1,
    CMD_CNT_WR  = 8'hF2,
    CMD_CNT_RD  = 8'hF3,
    CMD_IRQ_CLR = 8'hF5
  } cmd_e;

  // Bytes allowed per request for a burst selector value.
  function automatic logic [BCNT_W:0] burst_bytes(input logic [1:0] sel);
    logic [BCNT_W:0] n;
    case (sel)
      2'b00:   n = (BCNT_W+1)'(1);
      2'b01:   n = (BCNT_W+1)'(4);
      2'b10:   n = (BCNT_W+1)'(8);
      default: n = (BCNT_W+1)'(MAX_BURST);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              reg_stb,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_cmd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_en,
  input  logic [CNT_W-1:0]  eng_remain,
  output logic              cfg_wr,
  output logic              cfg_en_bit,
  output logic              autold,
  output logic [1:0]        burst_sel,
  output logic [CNT_W-1:0]  prog_cnt,
  output logic              eot_clr
);
  logic              hit_cnt_wr, hit_cnt_rd;
  logic              wphase_q, wphase_d;
  logic              rphase_q, rphase_d;
  logic [DATA_W-1:0] lo_stage_q, lo_stage_d;
  logic [DATA_W-1:0] hi_latch_q, hi_latch_d;
  logic [CNT_W-1:0]  prog_q, prog_d;
  logic              autold_q, autold_d;
  logic [1:0]        burst_q, burst_d;

  assign hit_cnt_wr = reg_stb &  reg_wr & (reg_cmd == CMD_CNT_WR);
  assign hit_cnt_rd = reg_stb & ~reg_wr & (reg_cmd == CMD_CNT_RD);
  assign cfg_wr     = reg_stb &  reg_wr & (reg_cmd == CMD_CFG_WR);
  assign cfg_en_bit = reg_wdata[3];
  assign eot_clr    = reg_stb &  reg_wr & (reg_cmd == CMD_IRQ_CLR) & reg_wdata[0];

  always_comb begin
    wphase_d   = wphase_q;
    rphase_d   = rphase_q;
    lo_stage_d = lo_stage_q;
    hi_latch_d = hi_latch_q;
    prog_d     = prog_q;
    autold_d   = autold_q;
    burst_d    = burst_q;
    if (reg_stb) begin
      if (hit_cnt_wr) begin
        if (!wphase_q) begin
          lo_stage_d = reg_wdata;
          wphase_d   = 1'b1;
        end else begin
          prog_d   = {reg_wdata, lo_stage_q};
          wphase_d = 1'b0;
        end
      end else begin
        wphase_d = 1'b0;
      end
      if (hit_cnt_rd) begin
        if (!rphase_q) hi_latch_d = eng_remain[CNT_W-1:DATA_W];
        rphase_d = ~rphase_q;
      end else begin
        rphase_d = 1'b0;
      end
    end
    if (cfg_wr) begin
      autold_d = reg_wdata[2];
      burst_d  = reg_wdata[1:0];
    end
    if (bus_rst) autold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wphase_q   <= 1'b0;
      rphase_q   <= 1'b0;
      lo_stage_q <= '0;
      hi_latch_q <= '0;
      prog_q     <= '0;
      autold_q   <= 1'b0;
      burst_q    <= 2'b00;
    end else begin
      wphase_q   <= wphase_d;
      rphase_q   <= rphase_d;
      lo_stage_q <= lo_stage_d;
      hi_latch_q <= hi_latch_d;
      prog_q     <= prog_d;
      autold_q   <= autold_d;
      burst_q    <= burst_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_stb && !reg_wr) begin
      if (reg_cmd == CMD_CFG_RD)
        reg_rdata = {4'b0000, eng_en, autold_q, burst_q};
      else if (reg_cmd == CMD_CNT_RD)
        reg_rdata = rphase_q ? hi_latch_q : eng_remain[DATA_W-1:0];
    end
  end

  assign autold    = autold_q;
  assign burst_sel = burst_q;
  assign prog_cnt  = prog_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             cfg_wr,
  input  logic             cfg_en_bit,
  input  logic             autold,
  input  logic [BCNT_W:0]  blen,
  input  logic [CNT_W-1:0] prog_cnt,
  input  logic             eot_clr,
  input  logic             dack,
  output logic             dreq,
  output logic             en,
  output logic             eot,
  output logic [CNT_W-1:0] remain
);
  logic              en_q, en_d;
  logic              gap_q, gap_d;
  logic              eot_q, eot_d;
  logic              eot_set;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              burst_last;

  assign dreq       = en_q & ~gap_q & (rem_q != '0);
  assign burst_last = ({1'b0, bcnt_q} == (blen - 1'b1));

  always_comb begin
    en_d    = en_q;
    gap_d   = gap_q;
    bcnt_d  = bcnt_q;
    rem_d   = rem_q;
    eot_set = 1'b0;
    if (bus_rst) begin
      en_d   = 1'b0;
      gap_d  = 1'b0;
      bcnt_d = '0;
    end else if (cfg_wr) begin
      if (cfg_en_bit) begin
        en_d   = 1'b1;
        rem_d  = prog_cnt;
        gap_d  = 1'b0;
        bcnt_d = '0;
      end else if (en_q) begin
        en_d    = 1'b0;
        eot_set = 1'b1;
        gap_d   = 1'b0;
        bcnt_d  = '0;
      end
    end else if (en_q) begin
      if (rem_q == '0) begin
        if (autold && (prog_cnt != '0)) begin
          rem_d  = prog_cnt;
          gap_d  = 1'b0;
          bcnt_d = '0;
        end else begin
          en_d    = 1'b0;
          eot_set = 1'b1;
        end
      end else if (gap_q) begin
        gap_d = 1'b0;
      end else if (dack) begin
        rem_d = rem_q - 1'b1;
        if (burst_last) begin
          bcnt_d = '0;
          gap_d  = 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end
    if (eot_set)      eot_d = 1'b1;
    else if (eot_clr) eot_d = 1'b0;
    else              eot_d = eot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      gap_q  <= 1'b0;
      eot_q  <= 1'b0;
      bcnt_q <= '0;
      rem_q  <= '0;
    end else begin
      en_q   <= en_d;
      gap_q  <= gap_d;
      eot_q  <= eot_d;
      bcnt_q <= bcnt_d;
      rem_q  <= rem_d;
    end
  end

  assign en     = en_q;
  assign eot    = eot_q;
  assign remain = rem_q;
endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_burst_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              reg_stb,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_cmd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic              xfer_done_irq
);
  logic             rst_n_s;
  logic             cfg_wr, cfg_en_bit, autold, eot_clr;
  logic [1:0]       burst_sel;
  logic [CNT_W-1:0] prog_cnt, remain;
  logic             en, eot;
  logic [BCNT_W:0]  blen;

  dma_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dma_regport i_regport (
    .clk(clk), .rst_n(rst_n_s), .bus_rst(bus_rst),
    .reg_stb(reg_stb), .reg_wr(reg_wr), .reg_cmd(reg_cmd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_en(en), .eng_remain(remain),
    .cfg_wr(cfg_wr), .cfg_en_bit(cfg_en_bit), .autold(autold),
    .burst_sel(burst_sel), .prog_cnt(prog_cnt), .eot_clr(eot_clr)
  );

  assign blen = burst_bytes(burst_sel);

  dma_xfer_engine i_engine (
    .clk(clk), .rst_n(rst_n_s), .bus_rst(bus_rst),
    .cfg_wr(cfg_wr), .cfg_en_bit(cfg_en_bit), .autold(autold),
    .blen(blen), .prog_cnt(prog_cnt), .eot_clr(eot_clr),
    .dack(dma_ack), .dreq(dma_req), .en(en), .eot(eot), .remain(remain)
  );

  assign xfer_done_irq = eot;
endmodule

// File: rtl/dma_burst_ctl_chk.sv
module dma_burst_ctl_chk
  import dma_burst_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rst,
  input logic             cfg_wr,
  input logic             cfg_en_bit,
  input logic             eot_clr,
  input logic             dreq,
  input logic             dack,
  input logic             en,
  input logic             eot,
  input logic [CNT_W-1:0] remain,
  input logic [BCNT_W:0]  blen
);
  logic [BCNT_W+1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (!dreq || cfg_wr) run_cnt <= '0;
    else if (dack)            run_cnt <= run_cnt + 1'b1;
  end

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && dack) |-> (run_cnt < {1'b0, blen}));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && dack && !cfg_wr && !bus_rst) |=> (remain == $past(remain) - 1'b1));

  // R12
  bus_rst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !en);

  // R10
  abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en_bit && en && !bus_rst) |=> (eot && !en && !dreq));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot && !eot_clr) |=> eot);

  // R7
  stop_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en) && !$past(bus_rst)) |-> eot);
endmodule

bind dma_burst_ctl dma_burst_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_rst(bus_rst), .cfg_wr(cfg_wr),
  .cfg_en_bit(cfg_en_bit), .eot_clr(eot_clr), .dreq(dma_req),
  .dack(dma_ack), .en(en), .eot(eot), .remain(remain), .blen(blen)
);

// File: tb/test_dma_burst_ctl.sv
module test_dma_burst_ctl;
  logic       clk = 1'b0;
  logic       rst_n, bus_rst, reg_stb, reg_wr, dma_ack;
  logic [7:0] reg_cmd, reg_wdata, reg_rdata;
  logic       dma_req, xfer_done_irq;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  dma_burst_ctl i_dma_burst_ctl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_stb(reg_stb),
    .reg_wr(reg_wr), .reg_cmd(reg_cmd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req(dma_req), .dma_ack(dma_ack),
    .xfer_done_irq(xfer_done_irq)
  );

  // {burst sel, count, expected bytes, expected request pulses}
  localparam int NV = 5;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 16'd3,  16'd3,  8'd3},
    {2'b01, 16'd10, 16'd10, 8'd3},
    {2'b10, 16'd8,  16'd8,  8'd1},
    {2'b11, 16'd20, 16'd20, 8'd2},
    {2'b10, 16'd19, 16'd19, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d);
    reg_stb = 1'b1; reg_wr = 1'b1; reg_cmd = cmd; reg_wdata = d;
    @(negedge clk);
    reg_stb = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d);
    reg_stb = 1'b1; reg_wr = 1'b0; reg_cmd = cmd;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_stb = 1'b0;
  endtask

  task automatic write_count(input logic [15:0] v);
    reg_write(8'hF2, v[7:0]);
    reg_write(8'hF2, v[15:8]);
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_read(8'hF3, lo);
    reg_read(8'hF3, hi);
    v = {hi, lo};
  endtask

  task automatic run_xfer(input int maxc, output int nbytes, output int npulse);
    bit prev = 1'b0;
    nbytes = 0; npulse = 0;
    for (int c = 0; c < maxc && !xfer_done_irq; c++) begin
      if (dma_req) begin
        nbytes++;
        if (!prev) npulse++;
      end
      prev = dma_req;
      dma_ack = dma_req;
      @(negedge clk);
    end
    dma_ack = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int nb, np;
    bit saw_req;
    rst_n = 1'b0; bus_rst = 1'b0; reg_stb = 1'b0; reg_wr = 1'b0;
    reg_cmd = 8'h00; reg_wdata = 8'h00; dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(dma_req == 1'b0, "R1 req", dma_req, 0);
    chk(xfer_done_irq == 1'b0, "R1 irq", xfer_done_irq, 0);
    reg_read(8'hF1, b);
    chk(b == 8'h00, "R1 cfg", b, 0);
    read_count(w);
    chk(w == 16'h0000, "R1 count", w, 0);

    // Vector table: R3 burst sizing, R7 completion
    for (int i = 0; i < NV; i++) begin
      write_count(VEC[i][39:24]);
      reg_write(8'hF0, {4'b0000, 1'b1, 1'b0, VEC[i][41:40]});
      run_xfer(400, nb, np);
      chk(nb == int'(VEC[i][23:8]), "R3 bytes", nb, int'(VEC[i][23:8]));
      chk(np == int'(VEC[i][7:0]), "R3 bursts", np, int'(VEC[i][7:0]));
      chk(xfer_done_irq == 1'b1, "R7 irq", xfer_done_irq, 1);
      reg_read(8'hF1, b);
      chk(b == {6'b0, VEC[i][41:40]}, "R7 cfg", b, {6'b0, VEC[i][41:40]});
      read_count(w);
      chk(w == 16'h0000, "R5 remain", w, 0);
      reg_write(8'hF5, 8'h01);
    end

    // R5 remaining count mid-transfer, burst of 16
    write_count(16'd100);
    reg_write(8'hF0, 8'h0B);
    dma_ack = 1'b1;
    repeat (5) @(negedge clk);
    dma_ack = 1'b0;
    read_count(w);
    chk(w == 16'd95, "R5 live", w, 95);
    // R6 re-enable reloads
    reg_write(8'hF0, 8'h0B);
    read_count(w);
    chk(w == 16'd100, "R6 reload", w, 100);
    // R10 abort
    reg_write(8'hF0, 8'h03);
    chk(dma_req == 1'b0, "R10 req", dma_req, 0);
    chk(xfer_done_irq == 1'b1, "R10 irq", xfer_done_irq, 1);
    reg_read(8'hF1, b);
    chk(b == 8'h03, "R2 cfg", b, 8'h03);
    // R11 sticky, W1C
    reg_write(8'hF5, 8'h00);
    chk(xfer_done_irq == 1'b1, "R11 keep", xfer_done_irq, 1);
    reg_write(8'hF5, 8'h01);
    chk(xfer_done_irq == 1'b0, "R11 clear", xfer_done_irq, 0);
    // R4 ack without request ignored
    dma_ack = 1'b1;
    repeat (3) @(negedge clk);
    dma_ack = 1'b0;
    read_count(w);
    chk(w == 16'd100, "R4 stray ack", w, 100);

    // R5 lone low byte does not commit
    write_count(16'h0010);
    reg_write(8'hF2, 8'h05);
    reg_write(8'hF0, 8'h08);
    read_count(w);
    chk(w == 16'h0010, "R5 partial", w, 16'h0010);
    reg_write(8'hF0, 8'h00);
    reg_write(8'hF5, 8'h01);

    // R8 auto-restart
    write_count(16'd2);
    reg_write(8'hF0, 8'h0C);
    run_xfer(12, nb, np);
    chk(nb > 2, "R8 bytes", nb, 3);
    chk(xfer_done_irq == 1'b0, "R8 irq", xfer_done_irq, 0);
    reg_read(8'hF1, b);
    chk(b == 8'h0C, "R8 cfg", b, 8'h0C);
    reg_write(8'hF0, 8'h00);
    reg_write(8'hF5, 8'h01);

    // R9 zero count, auto-restart set
    write_count(16'd0);
    reg_write(8'hF0, 8'h0C);
    saw_req = dma_req;
    repeat (3) begin
      @(negedge clk);
      saw_req = saw_req | dma_req;
    end
    chk(saw_req == 1'b0, "R9 req", saw_req, 0);
    chk(xfer_done_irq == 1'b1, "R9 irq", xfer_done_irq, 1);
    reg_read(8'hF1, b);
    chk(b == 8'h04, "R9 cfg", b, 8'h04);
    reg_write(8'hF5, 8'h01);

    // R12 bus reset
    write_count(16'h0030);
    reg_write(8'hF0, 8'h0E);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk(dma_req == 1'b0, "R12 req", dma_req, 0);
    chk(xfer_done_irq == 1'b0, "R12 irq", xfer_done_irq, 0);
    reg_read(8'hF1, b);
    chk(b == 8'h02, "R12 cfg", b, 8'h02);
    reg_write(8'hF0, 8'h0A);
    read_count(w);
    chk(w == 16'h0030, "R12 count kept", w, 16'h0030);
    reg_write(8'hF0, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    finished = 1'b1;
    $finish;
  end
endmodule